// File: doc/BRIEF.md
# Single-Channel DMA Controller with Multiplexed Upper Address

This block is one DMA channel. While it is idle it acts as a peripheral. A CPU selects one of its registers with a 4-bit select input, writes the 16-bit transfer address and the 16-bit count one byte at a time over an 8-bit data bus, writes a mode byte, and reads back the address, the count and a status byte. A single shared byte-pointer flip-flop decides whether an address or count access touches the low byte or the high byte.

When a device raises its request and the channel is enabled, the block asks for the bus with a hold request and waits for the hold acknowledge. It then runs a fixed cycle. In the first state it drives the upper address byte onto the data bus with a strobe, so that an external latch can capture it, and it drives the low address byte on its own address pins. In the next state it acknowledges the device and pulses the memory strobe that the cycle type selects. In the last state it updates its registers. The low 14 bits of the count hold one less than the number of transfers. The terminal-count output marks the final transfer. A mode bit can make the channel disable itself at that point.

Top module: `dma_chan`

## Requirements
- R1: After reset the hold request, acknowledge, strobes and terminal count are low, both bus output enables are low, the channel is disabled, the status flag is clear and the byte pointer selects the low byte.
- R2: Select code 0 reaches the address register and select code 1 reaches the count register. Each write or read of either register touches the low byte when the byte pointer is 0 and the high byte when it is 1, and then toggles the one shared pointer.
- R3: A write to select code 8 loads the mode: bit 0 enables the channel and bit 1 is the stop-at-terminal-count bit. The same write returns the byte pointer to the low byte.
- R4: A read of select code 8 returns the status byte. Bit 0 is the sticky terminal-count flag and all other bits are 0. The read clears the flag. Reads of other unused codes return 0.
- R5: The data-bus output enable is high only during a chip-selected read while idle, or during the address-latch state. The address-pin output enable is high only while the block owns the bus.
- R6: When the channel is enabled, the request is high and the block is idle, the hold request rises one cycle later and stays high until the cycle ends. The block waits in that state until the hold acknowledge is high.
- R7: The cycle after the hold acknowledge is seen is a single address-latch cycle. During it the strobe is high, the data bus carries address bits 15..8 and the address pins carry bits 7..0.
- R8: The next cycle is the transfer cycle, with the device acknowledge high. Count bits 15..14 select the cycle type: 01 pulses the memory-write strobe, 10 pulses the memory-read strobe, and 00 or 11 pulse neither.
- R9: After each cycle the address increments by 1 modulo 2^16. The low 14 count bits decrement by 1 modulo 2^14, and count bits 15..14 are kept.
- R10: The terminal-count output is high during the transfer cycle when the low 14 count bits are 0. When that cycle ends, the status flag is set.
- R11: With the stop bit set, the channel is disabled at the end of the terminal-count cycle, and no further hold request follows even though the request stays high. With the stop bit clear, the channel keeps running.
- R12: CPU writes and reads are ignored while the hold request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_cs | input | 1 | Chip select for CPU access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per byte |
| cpu_rd | input | 1 | CPU read strobe, one cycle per byte |
| reg_sel | input | 4 | Register select code |
| data_in | input | 8 | Data bus, input side |
| data_out | output | 8 | Data bus, output side |
| data_oe | output | 1 | Data bus output enable |
| addr_out | output | 8 | Low memory address byte |
| addr_oe | output | 1 | Address pin output enable |
| dev_req | input | 1 | Device transfer request |
| hold_req | output | 1 | Bus hold request |
| hold_ack | input | 1 | Bus hold acknowledge |
| addr_stb | output | 1 | Upper address latch strobe |
| dev_ack | output | 1 | Device acknowledge during transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| term_cnt | output | 1 | Terminal count, last transfer |

## Verification
Three updates can fall in the same end-of-cycle edge: the count wrap from 0 to 3FFF, the setting of the sticky status flag, and the automatic disable. The bench provokes them by programming small counts with the stop bit set and keeping the request high past the last transfer. It judges the result by the absence of any further hold request, and then by reading back the count, the address and the status flag, which must read 1 once and 0 on the next read. A second case with the stop bit clear checks that the wrap alone does not stop the channel.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_LATCH = 3'd2,
        ST_XFER  = 3'd3,
        ST_END   = 3'd4
    } cyc_state_e;

    localparam logic [3:0] SEL_ADDR = 4'd0;
    localparam logic [3:0] SEL_CNT  = 4'd1;
    localparam logic [3:0] SEL_MODE = 4'd8;

    localparam logic [1:0] TYPE_WRITE = 2'b01;
    localparam logic [1:0] TYPE_READ  = 2'b10;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_chan_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_ok,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [3:0]      sel,
    input  logic [DW-1:0]   wdata,
    input  logic            cyc_done,
    output logic [DW-1:0]   rdata,
    output logic [2*DW-1:0] addr,
    output logic [1:0]      cyc_type,
    output logic            tc_now,
    output logic            chan_en
);
    localparam int AW = 2 * DW;
    localparam int RW = CW + 2;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [RW-1:0] cnt;
        logic          en;
        logic          stop;
        logic          flag;
        logic          ptr;
    } regs_t;

    regs_t r_d, r_q;
    logic  do_wr, do_rd;
    logic [AW-1:0] cnt_ext;

    assign do_wr   = acc_ok && wr_en;
    assign do_rd   = acc_ok && rd_en && !wr_en;
    assign cnt_ext = AW'(r_q.cnt);

    always_comb begin
        r_d = r_q;
        if (do_wr) begin
            case (sel)
                SEL_ADDR: begin
                    if (r_q.ptr) r_d.addr[AW-1:DW] = wdata;
                    else         r_d.addr[DW-1:0]  = wdata;
                    r_d.ptr = !r_q.ptr;
                end
                SEL_CNT: begin
                    if (r_q.ptr) r_d.cnt[RW-1:DW] = wdata[RW-DW-1:0];
                    else         r_d.cnt[DW-1:0]  = wdata;
                    r_d.ptr = !r_q.ptr;
                end
                SEL_MODE: begin
                    r_d.en   = wdata[0];
                    r_d.stop = wdata[1];
                    r_d.ptr  = 1'b0;
                end
                default: ;
            endcase
        end else if (do_rd) begin
            case (sel)
                SEL_ADDR, SEL_CNT: r_d.ptr  = !r_q.ptr;
                SEL_MODE:          r_d.flag = 1'b0;
                default: ;
            endcase
        end
        if (cyc_done) begin
            r_d.addr        = r_q.addr + 1'b1;
            r_d.cnt[CW-1:0] = r_q.cnt[CW-1:0] - 1'b1;
            if (r_q.cnt[CW-1:0] == '0) begin
                r_d.flag = 1'b1;
                if (r_q.stop) r_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_ADDR: rdata = r_q.ptr ? r_q.addr[AW-1:DW] : r_q.addr[DW-1:0];
            SEL_CNT:  rdata = r_q.ptr ? cnt_ext[AW-1:DW]  : cnt_ext[DW-1:0];
            SEL_MODE: rdata = {{(DW-1){1'b0}}, r_q.flag};
            default:  rdata = '0;
        endcase
    end

    assign addr     = r_q.addr;
    assign cyc_type = r_q.cnt[RW-1:CW];
    assign tc_now   = (r_q.cnt[CW-1:0] == '0);
    assign chan_en  = r_q.en;

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (r_q.addr == $past(r_q.addr) + 1'b1));
    // R9
    type_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> (r_q.cnt[RW-1:CW] == $past(r_q.cnt[RW-1:CW])));
    // R11
    auto_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && tc_now && r_q.stop) |=> !r_q.en);
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && tc_now) |=> r_q.flag);
endmodule

// File: rtl/dma_cycle_fsm.sv
module dma_cycle_fsm
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       dev_req,
    input  logic       hold_ack,
    input  logic       tc_now,
    input  logic [1:0] cyc_type,
    output logic       idle,
    output logic       owns_bus,
    output logic       latch_st,
    output logic       cyc_done,
    output logic       hold_req,
    output logic       dev_ack,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       term_cnt
);
    typedef struct packed {
        cyc_state_e st;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        case (f_q.st)
            ST_IDLE:  if (chan_en && dev_req) f_d.st = ST_HOLD;
            ST_HOLD:  if (hold_ack)           f_d.st = ST_LATCH;
            ST_LATCH: f_d.st = ST_XFER;
            ST_XFER:  f_d.st = ST_END;
            ST_END:   f_d.st = ST_IDLE;
            default:  f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE};
        else        f_q <= f_d;
    end

    assign idle     = (f_q.st == ST_IDLE);
    assign hold_req = !idle;
    assign owns_bus = (f_q.st == ST_LATCH) || (f_q.st == ST_XFER) || (f_q.st == ST_END);
    assign latch_st = (f_q.st == ST_LATCH);
    assign dev_ack  = (f_q.st == ST_XFER);
    assign cyc_done = (f_q.st == ST_END);
    assign mem_wr   = dev_ack && (cyc_type == TYPE_WRITE);
    assign mem_rd   = dev_ack && (cyc_type == TYPE_READ);
    assign term_cnt = dev_ack && tc_now;

    // R8
    ack_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_st |=> dev_ack);
    // R10
    tc_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |-> (dev_ack && hold_req));
    // R6
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_q.st == ST_HOLD) && !hold_ack) |=> (f_q.st == ST_HOLD));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));
endmodule

// File: rtl/dma_bus_mux.sv
module dma_bus_mux #(
    parameter int DW = 8
) (
    input  logic            idle,
    input  logic            owns_bus,
    input  logic            latch_st,
    input  logic            cpu_cs,
    input  logic            cpu_rd,
    input  logic [DW-1:0]   reg_rdata,
    input  logic [2*DW-1:0] addr,
    output logic [DW-1:0]   data_out,
    output logic            data_oe,
    output logic [DW-1:0]   addr_out,
    output logic            addr_oe
);
    logic slave_rd;

    assign slave_rd = idle && cpu_cs && cpu_rd;
    assign data_oe  = latch_st || slave_rd;
    assign data_out = latch_st ? addr[2*DW-1:DW] : (slave_rd ? reg_rdata : '0);
    assign addr_out = owns_bus ? addr[DW-1:0] : '0;
    assign addr_oe  = owns_bus;
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
    parameter int DW = 8,
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_cs,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [3:0]    reg_sel,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic [DW-1:0] addr_out,
    output logic          addr_oe,
    input  logic          dev_req,
    output logic          hold_req,
    input  logic          hold_ack,
    output logic          addr_stb,
    output logic          dev_ack,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          term_cnt
);
    localparam int AW = 2 * DW;

    logic          idle, owns_bus, latch_st, cyc_done, tc_now, chan_en;
    logic [1:0]    cyc_type;
    logic [AW-1:0] addr;
    logic [DW-1:0] reg_rdata;
    logic          acc_ok;

    assign acc_ok = cpu_cs && idle;

    dma_regfile #(.DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_ok(acc_ok), .wr_en(cpu_wr), .rd_en(cpu_rd),
        .sel(reg_sel), .wdata(data_in), .cyc_done(cyc_done), .rdata(reg_rdata),
        .addr(addr), .cyc_type(cyc_type), .tc_now(tc_now), .chan_en(chan_en)
    );

    dma_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .dev_req(dev_req),
        .hold_ack(hold_ack), .tc_now(tc_now), .cyc_type(cyc_type), .idle(idle),
        .owns_bus(owns_bus), .latch_st(latch_st), .cyc_done(cyc_done),
        .hold_req(hold_req), .dev_ack(dev_ack), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .term_cnt(term_cnt)
    );

    dma_bus_mux #(.DW(DW)) u_mux (
        .idle(idle), .owns_bus(owns_bus), .latch_st(latch_st), .cpu_cs(cpu_cs),
        .cpu_rd(cpu_rd), .reg_rdata(reg_rdata), .addr(addr), .data_out(data_out),
        .data_oe(data_oe), .addr_out(addr_out), .addr_oe(addr_oe)
    );

    assign addr_stb = latch_st;

    // R5
    bus_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (addr_stb || !hold_req));
    // R7
    latch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |-> (addr_oe && data_oe));
    // R12
    frozen_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && !dev_ack && !$past(dev_ack) && !addr_stb) |-> $stable(addr));
endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cs = 0, cpu_wr = 0, cpu_rd = 0;
    logic [3:0] reg_sel = '0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out, addr_out;
    logic       data_oe, addr_oe, hold_req, addr_stb, dev_ack, mem_rd, mem_wr, term_cnt;
    logic       dev_req = 0, hold_ack = 0;

    int checks = 0, errors = 0;
    logic [15:0] m_addr, m_cnt;
    logic        m_en, m_stop, m_flag, m_ptr;

    always #5 clk = ~clk;

    dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .reg_sel(reg_sel), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .addr_out(addr_out), .addr_oe(addr_oe), .dev_req(dev_req), .hold_req(hold_req),
        .hold_ack(hold_ack), .addr_stb(addr_stb), .dev_ack(dev_ack), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .term_cnt(term_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_cnt(input logic [15:0] c);
        return {c[15:14], c[13:0] - 14'd1};
    endfunction

    task automatic cpu_write(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        cpu_cs = 1; cpu_wr = 1; reg_sel = s; data_in = d;
        @(negedge clk);
        cpu_cs = 0; cpu_wr = 0;
    endtask

    task automatic cpu_read(input logic [3:0] s, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cpu_cs = 1; cpu_rd = 1; reg_sel = s;
        #1 d = data_out; oe = data_oe;
        @(negedge clk);
        cpu_cs = 0; cpu_rd = 0;
    endtask

    // model-side register writes
    task automatic m_wr16(input logic [3:0] s, input logic [15:0] v);
        if (m_ptr) begin cpu_write(s, v[7:0]); m_ptr = 0; end
        cpu_write(s, v[7:0]);
        cpu_write(s, v[15:8]);
        if (s == 4'd0) m_addr = v; else m_cnt = v;
    endtask

    task automatic m_mode(input logic en, input logic stop);
        cpu_write(4'd8, {6'b0, stop, en});
        m_en = en; m_stop = stop; m_ptr = 0;
    endtask

    task automatic rd16(input string req, input logic [3:0] s, input logic [15:0] exp);
        logic [7:0] lo, hi;
        logic oe;
        m_mode(m_en, m_stop);
        cpu_read(s, lo, oe);
        chk(req, oe, 1'b1);
        cpu_read(s, hi, oe);
        chk(req, {hi, lo}, exp);
    endtask

    task automatic rd_status(input string req, input logic exp);
        logic [7:0] d;
        logic oe;
        cpu_read(4'd8, d, oe);
        chk(req, d, {7'b0, exp});
        m_flag = 0;
    endtask

    // one DMA cycle with request kept or dropped afterwards
    task automatic do_cycle(input logic keep_req);
        logic tc_e;
        tc_e = (m_cnt[13:0] == 14'd0);
        @(negedge clk); dev_req = 1;
        @(negedge clk);
        chk("R6 hold", hold_req, 1'b1);
        chk("R6 no ack", dev_ack, 1'b0);
        cpu_cs = 1; cpu_wr = 1; reg_sel = 4'd0; data_in = 8'hA5;
        @(negedge clk);
        cpu_cs = 0; cpu_wr = 0;
        chk("R6 waits", {hold_req, addr_stb}, 2'b10);
        hold_ack = 1;
        @(negedge clk);
        chk("R7 stb", addr_stb, 1'b1);
        chk("R7 hi", {data_oe, data_out}, {1'b1, m_addr[15:8]});
        chk("R7 lo", {addr_oe, addr_out}, {1'b1, m_addr[7:0]});
        @(negedge clk);
        chk("R8 ack", {dev_ack, addr_stb, data_oe}, 3'b100);
        chk("R8 strobes", {mem_wr, mem_rd}, {m_cnt[15:14] == 2'b01, m_cnt[15:14] == 2'b10});
        chk("R10 tc", term_cnt, tc_e);
        if (!keep_req) dev_req = 0;
        @(negedge clk);
        chk("R6 hold end", {hold_req, dev_ack, term_cnt}, 3'b100);
        hold_ack = 0;
        m_addr = m_addr + 16'd1;
        m_cnt = next_cnt(m_cnt);
        if (tc_e) begin m_flag = 1; if (m_stop) m_en = 0; end
        @(negedge clk);
        chk("R6 release", hold_req, 1'b0);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic oe;
        void'($urandom(32'h1d2c3b4a));
        m_addr = 0; m_cnt = 0; m_en = 0; m_stop = 0; m_flag = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        chk("R1 outputs", {hold_req, dev_ack, addr_stb, mem_rd, mem_wr, term_cnt, data_oe, addr_oe}, 8'h00);
        rst_n = 1;
        dev_req = 1;
        repeat (3) @(negedge clk);
        chk("R1 disabled", hold_req, 1'b0);
        dev_req = 0;
        rd_status("R1 flag", 1'b0);
        cpu_read(4'd0, d, oe);
        chk("R1 ptr low", d, 8'h00);
        m_ptr = 1;
        cpu_read(4'd0, d, oe);
        m_ptr = 0;

        // R2: shared pointer across registers
        cpu_write(4'd0, 8'h34);
        cpu_write(4'd1, 8'h12);
        cpu_read(4'd0, d, oe);
        chk("R2 shared ptr lo", d, 8'h34);
        cpu_read(4'd1, d, oe);
        chk("R2 shared ptr hi", d, 8'h12);
        // R3: mode write resets pointer
        cpu_write(4'd0, 8'h77);
        m_mode(0, 0);
        cpu_read(4'd0, d, oe);
        chk("R3 ptr reset", d, 8'h77);
        m_ptr = 1;
        cpu_read(4'd5, d, oe);
        chk("R4 unused", {oe, d}, 9'h100);
        @(negedge clk);
        chk("R5 idle oe", {data_oe, addr_oe}, 2'b00);
        m_ptr = 1;

        // directed: wrap across 8-bit and 16-bit boundaries, stop bit clear
        m_wr16(4'd0, 16'hFFFF);
        m_wr16(4'd1, 16'h4000);
        m_mode(1, 0);
        do_cycle(0);
        chk("R11 runs on", m_en, 1'b1);
        do_cycle(0);
        rd16("R9 addr wrap", 4'd0, 16'h0001);
        rd16("R9 cnt wrap", 4'd1, 16'h7FFE);
        rd_status("R10 flag", 1'b1);
        rd_status("R4 cleared", 1'b0);

        // random rounds, stop bit set, request held past the end
        for (int t = 0; t < 8; t++) begin
            logic [15:0] a;
            logic [13:0] n;
            logic [1:0]  ty;
            a  = 16'($urandom);
            n  = 14'($urandom_range(0, 4));
            ty = 2'($urandom);
            m_wr16(4'd0, a);
            m_wr16(4'd1, {ty, n});
            m_mode(1, 1);
            for (int k = 0; k <= int'(n); k++) do_cycle(k == int'(n));
            repeat (4) begin
                @(negedge clk);
                chk("R11 stopped", hold_req, 1'b0);
            end
            dev_req = 0;
            rd16("R9 addr", 4'd0, m_addr);
            rd16("R9 cnt", 4'd1, m_cnt);
            rd_status("R11 flag", 1'b1);
            rd_status("R4 clear", 1'b0);
        end
        // R12: the write during the hold state must not land
        m_wr16(4'd0, 16'h1200);
        m_wr16(4'd1, 16'h0005);
        m_mode(1, 0);
        do_cycle(0);
        rd16("R12 ignored", 4'd0, 16'h1201);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule